// File: doc/BRIEF.md
# Parallel Flash Read-Mode Controller

This block is the device-side read path of a byte-wide parallel flash. The address space holds 16 Mbit as 32 independently erasable blocks of 64 KB each. The block keeps a read-mode state and selects which byte goes onto the data bus: a byte from the array, the status byte of the program/erase engine, or one of two identification bytes. A command decoder elsewhere sends one-cycle request pulses to change the mode. The program/erase engine supplies a busy flag, a start pulse and the live status byte.

All control strobes are sampled on the system clock, and every output is registered. The status byte is captured at the clock edge where the second of the two active-low read strobes (chip enable, output enable) is seen low. It is held until one of the two strobes goes high and falls again. The array is a synchronous memory whose depth is a parameter; reads use the low `ARR_AW` address bits. The engine loads the array through a write port.

The mode machine has four states. The transitions are:

| State | Purpose | Leaves on |
|-------|---------|-----------|
| `ST_ARRAY` | array bytes, entered on reset | any request |
| `ST_STATUS` | status byte | any request |
| `ST_IDENT` | identification bytes | any request |
| `ST_SUSPEND` | status byte while an erase is suspended | any request |

Requests are taken in this priority order, highest first:

1. `op_start` goes to `ST_STATUS`.
2. `req_suspend` goes to `ST_SUSPEND`.
3. `req_status` goes to `ST_STATUS`.
4. `req_ident` goes to `ST_IDENT`.
5. `req_array` goes to `ST_ARRAY`.

When no request is present, the state is held.

Top module: `flash_read_ctrl`

## Requirements
- R1: After reset, `dq_oe` and `dq_out` are 0 and the mode is array read.
- R2: `dq_oe` is 1 in the cycle after a clock edge that samples `we_n`=1, `ce_n`=0 and `oe_n`=0. Otherwise it is 0 one cycle after that edge.
- R3: In array mode with the bus driven, `dq_out` after an edge equals the array byte stored at the low `ARR_AW` bits of `addr` sampled at that edge. The upper address bits are ignored.
- R4: Whenever `dq_oe` is 0, `dq_out` is 0x00.
- R5: The status byte is captured from `stat_in` at the edge where `ce_n` and `oe_n` are first both seen low. In status reads, `addr` has no effect.
- R6: While both strobes stay low, the captured status does not change, even if `stat_in` changes. Raising either strobe and lowering it again captures a fresh value.
- R7: An `op_start` pulse switches the mode to status read.
- R8: While `busy` is 1, a read returns the captured status whatever the mode. Reads return to the selected mode once `busy` is 0.
- R9: A `req_suspend` pulse puts the block in suspend, where reads return status. It stays there until any request pulse arrives.
- R10: In identification mode, address 0 returns `MFR_ID` (default 0xA7), address 1 returns `DEV_ID` (default 0x3C), and any other full 21-bit address returns 0x00.
- R11: Request pulses take the priority op_start > suspend > status > ident > array. A pulse seen at edge k updates the mode at k, and reads sampled from edge k+1 on use the new mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ce_n | input | 1 | chip enable, active low |
| oe_n | input | 1 | output enable, active low |
| we_n | input | 1 | write enable, active low |
| addr | input | 21 | byte address |
| busy | input | 1 | program/erase engine busy |
| op_start | input | 1 | pulse: program or erase started |
| req_suspend | input | 1 | pulse: erase suspended |
| req_status | input | 1 | pulse: select status read |
| req_ident | input | 1 | pulse: select identification read |
| req_array | input | 1 | pulse: select array read |
| stat_in | input | 8 | live status byte from the engine |
| prog_we | input | 1 | array write strobe |
| prog_addr | input | 10 | array write index |
| prog_data | input | 8 | array write data |
| dq_out | output | 8 | data bus value |
| dq_oe | output | 1 | data bus drive enable |

## Verification
Every bus result is due one clock after the edge that samples its cause. A strobe, address, busy or status change seen at edge k appears on `dq_oe`/`dq_out` after edge k. A mode request seen at edge k affects reads sampled from edge k+1. The bench drives inputs on the falling edge and updates a behavioural model on the rising edge with the same sampled inputs. It compares the bus on the next falling edge, every cycle. Directed checks read the bus one falling edge after each stimulus, and a mode pulse is always followed by one idle cycle before the read.

// File: rtl/flash_rd_pkg.sv
package flash_rd_pkg;

    typedef enum logic [1:0] {
        ST_ARRAY   = 2'd0,
        ST_STATUS  = 2'd1,
        ST_IDENT   = 2'd2,
        ST_SUSPEND = 2'd3
    } rd_mode_e;

    typedef enum logic [1:0] {
        SRC_ARRAY  = 2'd0,
        SRC_STATUS = 2'd1,
        SRC_IDENT  = 2'd2
    } rd_src_e;

endpackage

// File: rtl/frd_mode_fsm.sv
module frd_mode_fsm
    import flash_rd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     busy,
    input  logic     op_start,
    input  logic     req_suspend,
    input  logic     req_status,
    input  logic     req_ident,
    input  logic     req_array,
    output rd_mode_e mode_q,
    output rd_src_e  src
);

    rd_mode_e mode_d;

    // next state: fixed priority among request pulses
    always_comb begin
        mode_d = mode_q;
        if (op_start)         mode_d = ST_STATUS;
        else if (req_suspend) mode_d = ST_SUSPEND;
        else if (req_status)  mode_d = ST_STATUS;
        else if (req_ident)   mode_d = ST_IDENT;
        else if (req_array)   mode_d = ST_ARRAY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_ARRAY;
        else        mode_q <= mode_d;
    end

    // data source selected by the current state; busy overrides
    always_comb begin
        src = SRC_STATUS;
        unique case (mode_q)
            ST_ARRAY:   src = busy ? SRC_STATUS : SRC_ARRAY;
            ST_IDENT:   src = busy ? SRC_STATUS : SRC_IDENT;
            ST_STATUS:  src = SRC_STATUS;
            ST_SUSPEND: src = SRC_STATUS;
            default:    src = SRC_STATUS;
        endcase
    end

endmodule

// File: rtl/frd_strobe_latch.sv
module frd_strobe_latch #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [DATA_W-1:0] stat_in,
    output logic              drive_q,
    output logic              both_low_q,
    output logic [DATA_W-1:0] stat_q
);

    logic both_low;
    assign both_low = !ce_n && !oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q    <= 1'b0;
            both_low_q <= 1'b0;
            stat_q     <= '0;
        end else begin
            drive_q    <= both_low && we_n;
            both_low_q <= both_low;
            // capture on the edge where the later strobe is first seen low
            if (both_low && !both_low_q) stat_q <= stat_in;
        end
    end

endmodule

// File: rtl/frd_array_mem.sv
module frd_array_mem #(
    parameter int DATA_W = 8,
    parameter int AW     = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata_q
);

    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
        rdata_q <= store[raddr];
    end

endmodule

// File: rtl/flash_read_ctrl.sv
module flash_read_ctrl
    import flash_rd_pkg::*;
#(
    parameter int          ADDR_W = 21,
    parameter int          DATA_W = 8,
    parameter int          ARR_AW = 10,
    parameter logic [7:0]  MFR_ID = 8'hA7,
    parameter logic [7:0]  DEV_ID = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    input  logic              op_start,
    input  logic              req_suspend,
    input  logic              req_status,
    input  logic              req_ident,
    input  logic              req_array,
    input  logic [DATA_W-1:0] stat_in,
    input  logic              prog_we,
    input  logic [ARR_AW-1:0] prog_addr,
    input  logic [DATA_W-1:0] prog_data,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam logic [ADDR_W-1:0] ID_MFR_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ID_DEV_ADDR = ADDR_W'(1);

    rd_mode_e          mode_q;
    rd_src_e           src, src_q;
    logic              both_low_q;
    logic [DATA_W-1:0] stat_q, arr_q, id_q;

    frd_mode_fsm fsm_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .op_start    (op_start),
        .req_suspend (req_suspend),
        .req_status  (req_status),
        .req_ident   (req_ident),
        .req_array   (req_array),
        .mode_q      (mode_q),
        .src         (src)
    );

    frd_strobe_latch #(.DATA_W(DATA_W)) strobe_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .stat_in    (stat_in),
        .drive_q    (dq_oe),
        .both_low_q (both_low_q),
        .stat_q     (stat_q)
    );

    frd_array_mem #(.DATA_W(DATA_W), .AW(ARR_AW)) mem_i (
        .clk     (clk),
        .we      (prog_we),
        .waddr   (prog_addr),
        .wdata   (prog_data),
        .raddr   (addr[ARR_AW-1:0]),
        .rdata_q (arr_q)
    );

    // identification decode and source select, registered with the array read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q <= SRC_ARRAY;
            id_q  <= '0;
        end else begin
            src_q <= src;
            if (addr == ID_MFR_ADDR)      id_q <= DATA_W'(MFR_ID);
            else if (addr == ID_DEV_ADDR) id_q <= DATA_W'(DEV_ID);
            else                          id_q <= '0;
        end
    end

    always_comb begin
        dq_out = '0;
        if (dq_oe) begin
            unique case (src_q)
                SRC_ARRAY:  dq_out = arr_q;
                SRC_IDENT:  dq_out = id_q;
                SRC_STATUS: dq_out = stat_q;
                default:    dq_out = stat_q;
            endcase
        end
    end

endmodule

// File: rtl/flash_read_ctrl_chk.sv
module flash_read_ctrl_chk
    import flash_rd_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic       we_n,
    input logic       op_start,
    input logic       req_suspend,
    input logic       req_status,
    input logic       req_ident,
    input logic       req_array,
    input logic       dq_oe,
    input rd_mode_e   mode_q,
    input logic       both_low_q,
    input logic [7:0] stat_q
);

    logic any_req;
    assign any_req = op_start || req_suspend || req_status || req_ident || req_array;

    AST_DRIVE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n && !ce_n && !oe_n) |=> dq_oe); // R2

    AST_DRIVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n || ce_n || oe_n) |=> !dq_oe); // R2

    AST_STATUS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && both_low_q) |=> $stable(stat_q)); // R6

    AST_START_TO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> (mode_q == ST_STATUS)); // R7

    AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_SUSPEND && !any_req) |=> (mode_q == ST_SUSPEND)); // R9

    AST_STATUS_OVER_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_status && !op_start && !req_suspend) |=> (mode_q == ST_STATUS)); // R11

endmodule

bind flash_read_ctrl flash_read_ctrl_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .we_n        (we_n),
    .op_start    (op_start),
    .req_suspend (req_suspend),
    .req_status  (req_status),
    .req_ident   (req_ident),
    .req_array   (req_array),
    .dq_oe       (dq_oe),
    .mode_q      (mode_q),
    .both_low_q  (both_low_q),
    .stat_q      (stat_q)
);

// File: tb/flash_read_ctrl_tb_top.sv
module flash_read_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_N      = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [20:0] addr = '0;
    logic        busy = 1'b0;
    logic [4:0]  reqs = '0;   // [4] op_start [3] suspend [2] status [1] ident [0] array
    logic [7:0]  stat_in = '0;
    logic        prog_we = 1'b0;
    logic [9:0]  prog_addr = '0;
    logic [7:0]  prog_data = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_read_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ce_n        (ce_n),
        .oe_n        (oe_n),
        .we_n        (we_n),
        .addr        (addr),
        .busy        (busy),
        .op_start    (reqs[4]),
        .req_suspend (reqs[3]),
        .req_status  (reqs[2]),
        .req_ident   (reqs[1]),
        .req_array   (reqs[0]),
        .stat_in     (stat_in),
        .prog_we     (prog_we),
        .prog_addr   (prog_addr),
        .prog_data   (prog_data),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe)
    );

    // ---------------- behavioural reference model ----------------
    int   m_mode;   // 0 array, 1 status, 2 ident, 3 suspend
    int   m_src;    // 0 array, 1 status, 2 ident
    int   m_oe, m_dq, m_stat, m_prev_low;
    bit   m_valid = 0;
    int   m_mem [MEM_N];

    function automatic int pat(int i);
        return (i * 37 + 11) % 256;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_src = 0; m_oe = 0; m_dq = 0; m_stat = 0; m_prev_low = 0;
        end else begin
            int both, rd, arr_b, id_b, val;
            both  = (!ce_n && !oe_n) ? 1 : 0;
            rd    = (both == 1 && we_n) ? 1 : 0;
            if (busy || m_mode == 1 || m_mode == 3) m_src = 1;
            else if (m_mode == 2)                   m_src = 2;
            else                                    m_src = 0;
            if (both == 1 && m_prev_low == 0) m_stat = int'(stat_in);
            arr_b = m_mem[int'(addr) % MEM_N];
            id_b  = (addr == 21'd0) ? 8'hA7 : (addr == 21'd1) ? 8'h3C : 0;
            val   = (m_src == 0) ? arr_b : (m_src == 2) ? id_b : m_stat;
            m_oe  = rd;
            m_dq  = (rd == 1) ? val : 0;
            if (prog_we) m_mem[int'(prog_addr)] = int'(prog_data);
            if (reqs[4])      m_mode = 1;
            else if (reqs[3]) m_mode = 3;
            else if (reqs[2]) m_mode = 1;
            else if (reqs[1]) m_mode = 2;
            else if (reqs[0]) m_mode = 0;
            m_prev_low = both;
        end
        m_valid = 1;
    end

    task automatic check(string tag, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model, away from the rising edge
    always @(negedge clk) begin
        if (m_valid && !done) begin
            string tag;
            if (m_oe == 0)      tag = "R4";
            else if (m_src == 1) tag = "R5";
            else if (m_src == 2) tag = "R10";
            else                tag = "R3";
            check("R2 model dq_oe", int'(dq_oe), m_oe);
            check({tag, " model dq_out"}, int'(dq_out), m_dq);
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse(logic [4:0] v);
        reqs = v;
        tick();
        reqs = '0;
    endtask

    task automatic strobes(logic c, logic o, logic w);
        ce_n = c; oe_n = o; we_n = w;
    endtask

    initial begin
        repeat (3) tick();
        check("R1 reset dq_oe", int'(dq_oe), 0);
        check("R1 reset dq_out", int'(dq_out), 0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < MEM_N; i++) begin
            prog_we = 1'b1; prog_addr = 10'(i); prog_data = 8'(pat(i));
            tick();
        end
        prog_we = 1'b0;
        tick();

        // array reads, mode after reset
        strobes(0, 0, 1); addr = 21'd5; tick();
        check("R1 array after reset", int'(dq_out), pat(5));
        check("R2 drive on", int'(dq_oe), 1);
        addr = 21'h1F0123; tick();
        check("R3 address follow", int'(dq_out), pat(291));
        oe_n = 1'b1; tick();
        check("R2 oe high", int'(dq_oe), 0);
        check("R4 bus quiet", int'(dq_out), 0);
        oe_n = 1'b0; we_n = 1'b0; tick();
        check("R2 we low", int'(dq_oe), 0);
        strobes(1, 1, 1);

        // status capture and hold
        pulse(5'b00100);
        stat_in = 8'h80; strobes(0, 0, 1); addr = 21'd7; tick();
        check("R5 capture", int'(dq_out), 8'h80);
        stat_in = 8'h81; addr = 21'd9; tick();
        check("R6 held", int'(dq_out), 8'h80);
        oe_n = 1'b1; tick();
        oe_n = 1'b0; tick();
        check("R6 refresh", int'(dq_out), 8'h81);
        ce_n = 1'b1; tick();
        stat_in = 8'h82; ce_n = 1'b0; tick();
        check("R5 later strobe ce", int'(dq_out), 8'h82);
        strobes(1, 1, 1);

        // identification
        pulse(5'b00010);
        strobes(0, 0, 1); addr = 21'd0; tick();
        check("R10 mfr", int'(dq_out), 8'hA7);
        addr = 21'd1; tick();
        check("R10 dev", int'(dq_out), 8'h3C);
        addr = 21'd2; tick();
        check("R10 other", int'(dq_out), 0);
        addr = 21'h100000; tick();
        check("R10 high addr", int'(dq_out), 0);
        strobes(1, 1, 1);

        // busy override
        pulse(5'b00001);
        strobes(0, 0, 1); addr = 21'd10; tick();
        check("R11 array req", int'(dq_out), pat(10));
        busy = 1'b1; oe_n = 1'b1; tick();
        stat_in = 8'h01; oe_n = 1'b0; tick();
        check("R8 busy status", int'(dq_out), 8'h01);
        busy = 1'b0; tick();
        check("R8 busy clear", int'(dq_out), pat(10));
        strobes(1, 1, 1);

        // op start
        stat_in = 8'h80;
        pulse(5'b10000);
        strobes(0, 0, 1); tick();
        check("R7 start status", int'(dq_out), 8'h80);
        strobes(1, 1, 1);

        // suspend
        pulse(5'b01000);
        stat_in = 8'hC0; strobes(0, 0, 1); addr = 21'd10; tick();
        check("R9 suspend status", int'(dq_out), 8'hC0);
        repeat (4) tick();
        check("R9 suspend held", int'(dq_out), 8'hC0);
        strobes(1, 1, 1);
        pulse(5'b00001);
        strobes(0, 0, 1); tick();
        check("R9 leave suspend", int'(dq_out), pat(10));
        strobes(1, 1, 1);

        // priority
        stat_in = 8'h44;
        pulse(5'b00110);
        strobes(0, 0, 1); addr = 21'd0; tick();
        check("R11 status over ident", int'(dq_out), 8'h44);
        strobes(1, 1, 1);
        pulse(5'b00011);
        strobes(0, 0, 1); addr = 21'd1; tick();
        check("R11 ident over array", int'(dq_out), 8'h3C);
        strobes(1, 1, 1);
        stat_in = 8'h55;
        pulse(5'b10001);
        strobes(0, 0, 1); tick();
        check("R11 start over array", int'(dq_out), 8'h55);
        strobes(1, 1, 1);
        pulse(5'b01100);
        strobes(0, 0, 1); tick();
        check("R11 suspend over status", int'(dq_out), 8'h55);
        strobes(1, 1, 1);

        repeat (2) tick();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule